// File: doc/BRIEF.md
# Pointer Data Address Generator

This block forms data-space addresses for indirect loads and stores. It works from three 16-bit pointers, each made of two adjacent general registers. A request carries the pointer select, an addressing mode, a 6-bit displacement and the current pointer value.

One cycle later the block returns four things: the effective address, the updated pointer with a write-back strobe, the index of the low register of the chosen pair, and the region of the linear data map the address falls in. The low addresses of that map hold the register file, the I/O locations come next, and SRAM follows them.

A separate two-cycle unit adds a small unsigned immediate to a 16-bit register-pair value, or subtracts one from it. It reports the result together with zero, carry, negative, overflow and sign flags.

Top module: `ptr_agen`

## Requirements
- R1: After reset, and before any request, every output is 0.
- R2: The pointer select uses code 0 for X, 1 for Y and 2 for Z. `ptr_reg_o` reports the even low-byte register of the pair: 26 for X, 28 for Y and 30 for Z.
- R3: Mode 0 (plain) gives `ea_o` equal to the pointer, `ptr_wb_o` = 0 and `ptr_new_o` equal to the unchanged pointer. Every address result appears one clock after the request edge, with `ea_valid_o` = 1.
- R4: Mode 1 (post-increment) gives `ea_o` equal to the pointer and `ptr_new_o` = pointer + 1 modulo 2^16, with `ptr_wb_o` = 1.
- R5: Mode 2 (pre-decrement) gives `ptr_new_o` = pointer - 1 modulo 2^16 and `ea_o` = `ptr_new_o`, with `ptr_wb_o` = 1. A pointer of 0 wraps to 0xFFFF.
- R6: Mode 3 (displacement) on Y or Z gives `ea_o` = pointer + q, where q is unsigned 0 to 63 and the sum wraps modulo 2^16. The pointer is not written back: `ptr_wb_o` = 0.
- R7: Mode 3 on X, or select code 3, is rejected. One clock later both `ea_valid_o` and `ptr_wb_o` are 0.
- R8: `region_o` decodes `ea_o` as follows: 0 for 0x00 to 0x1F (registers), 1 for 0x20 to 0x5F (I/O), 2 for 0x60 to 0xDF (SRAM) and 3 for anything above.
- R9: A word add gives `word_res_o` = value + immediate modulo 2^16. `word_done_o` pulses for one clock two clocks after the start edge.
- R10: A word subtract gives `word_res_o` = value - immediate modulo 2^16, with the same timing as R9.
- R11: `word_flags_o` is laid out as bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. C is the 16-bit carry on add or the borrow on subtract. V is signed overflow, N is result bit 15, Z is set for a zero result, and S = N xor V.
- R12: A start that arrives while a word operation is in progress is ignored and produces no result or done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Address request |
| ptr_sel_i | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| mode_i | input | 2 | Mode (0 plain, 1 post-inc, 2 pre-dec, 3 displacement) |
| disp_i | input | 6 | Unsigned displacement q |
| ptr_i | input | 16 | Current pointer value |
| ea_valid_o | output | 1 | Address result valid |
| ea_o | output | 16 | Effective address |
| region_o | output | 2 | Region of ea_o |
| ptr_new_o | output | 16 | Updated pointer value |
| ptr_wb_o | output | 1 | Pointer write-back strobe |
| ptr_reg_o | output | 5 | Low register index of the pair |
| word_start_i | input | 1 | Start a word operation |
| word_sub_i | input | 1 | 1 subtract, 0 add |
| word_val_i | input | 16 | Register-pair value |
| word_imm_i | input | 6 | Unsigned immediate |
| word_done_o | output | 1 | Word result strobe |
| word_res_o | output | 16 | Word result |
| word_flags_o | output | 5 | {S,V,N,Z,C} |

## Verification
Address results are registered once, so they are due at the first rising edge after the request edge. Word results pass a low-byte stage and then a high-byte stage, so they are due at the second rising edge after the start edge. The bench drives inputs on falling edges and reads outputs at the falling edge that follows the edge where a result is due. For the busy case it also reads the outputs one clock later, to confirm that the ignored start left no second done pulse.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN    = 2'd0,
    MODE_POST_INC = 2'd1,
    MODE_PRE_DEC  = 2'd2,
    MODE_DISP     = 2'd3
  } agen_mode_e;

  typedef enum logic [1:0] {
    SEL_X   = 2'd0,
    SEL_Y   = 2'd1,
    SEL_Z   = 2'd2,
    SEL_RSV = 2'd3
  } ptr_sel_e;

  typedef enum logic [1:0] {
    RGN_REGS = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef struct packed {
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } word_flags_t;
endpackage

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc import ptr_agen_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int DISP_W   = 6,
  parameter int REG_W    = 5,
  parameter int PTR_BASE = 26,
  parameter int PTR_CNT  = 3
) (
  input  ptr_sel_e          sel_i,
  input  agen_mode_e        mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] new_ptr_o,
  output logic              wb_o,
  output logic [REG_W-1:0]  reg_o
);
  localparam int SEL_N = 4;

  logic [REG_W-1:0] pair_lo [SEL_N];

  for (genvar g = 0; g < SEL_N; g++) begin : g_pair
    if (g < PTR_CNT) begin : g_used
      assign pair_lo[g] = REG_W'(PTR_BASE + 2 * g);
    end else begin : g_rsv
      assign pair_lo[g] = '0;
    end
  end

  logic sel_ok;
  assign sel_ok = (sel_i != SEL_RSV);
  assign reg_o  = pair_lo[sel_i];

  always_comb begin
    ea_o      = ptr_i;
    new_ptr_o = ptr_i;
    wb_o      = 1'b0;
    ok_o      = sel_ok;
    unique case (mode_i)
      MODE_PLAIN: ;
      MODE_POST_INC: begin
        new_ptr_o = ptr_i + ADDR_W'(1);
        wb_o      = 1'b1;
      end
      MODE_PRE_DEC: begin
        new_ptr_o = ptr_i - ADDR_W'(1);
        ea_o      = new_ptr_o;
        wb_o      = 1'b1;
      end
      MODE_DISP: begin
        // X has no displacement form
        ea_o = ptr_i + ADDR_W'(disp_i);
        if (sel_i == SEL_X) ok_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/data_region_decode.sv
module data_region_decode import ptr_agen_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int REG_CNT    = 32,
  parameter int IO_CNT     = 64,
  parameter int SRAM_BYTES = 128
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  localparam logic [ADDR_W:0] IO_LIM   = (ADDR_W+1)'(REG_CNT);
  localparam logic [ADDR_W:0] SRAM_LIM = (ADDR_W+1)'(REG_CNT + IO_CNT);
  localparam logic [ADDR_W:0] TOP_LIM  = (ADDR_W+1)'(REG_CNT + IO_CNT + SRAM_BYTES);

  logic [ADDR_W:0] a;
  assign a = {1'b0, addr_i};

  always_comb begin
    if (a < IO_LIM)        region_o = RGN_REGS;
    else if (a < SRAM_LIM) region_o = RGN_IO;
    else if (a < TOP_LIM)  region_o = RGN_SRAM;
    else                   region_o = RGN_NONE;
  end
endmodule

// File: rtl/word_imm_unit.sv
module word_imm_unit import ptr_agen_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              done_o,
  output logic [DATA_W-1:0] res_o,
  output word_flags_t       flags_o
);
  localparam int HALF = DATA_W / 2;

  logic            busy_q, sub_q, cy_q;
  logic [HALF-1:0] lo_q, hi_q;
  logic [HALF:0]   lo_sum, hi_sum;
  logic [HALF:0]   imm_ext, cy_ext;
  logic            accept;

  assign accept  = start_i && !busy_q;
  assign imm_ext = (HALF+1)'(imm_i);
  assign cy_ext  = (HALF+1)'(cy_q);

  // stage 1: low byte with carry/borrow out
  assign lo_sum = sub_i ? ({1'b0, val_i[HALF-1:0]} - imm_ext)
                        : ({1'b0, val_i[HALF-1:0]} + imm_ext);
  // stage 2: high byte absorbs it
  assign hi_sum = sub_q ? ({1'b0, hi_q} - cy_ext) : ({1'b0, hi_q} + cy_ext);

  logic [DATA_W-1:0] res_d;
  word_flags_t       flags_d;
  assign res_d = {hi_sum[HALF-1:0], lo_q};

  always_comb begin
    flags_d.n = res_d[DATA_W-1];
    flags_d.z = (res_d == '0);
    flags_d.c = hi_sum[HALF];
    flags_d.v = sub_q ? (hi_q[HALF-1] && !res_d[DATA_W-1])
                      : (!hi_q[HALF-1] && res_d[DATA_W-1]);
    flags_d.s = flags_d.n ^ flags_d.v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sub_q   <= 1'b0;
      cy_q    <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      done_o  <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        sub_q  <= sub_i;
        cy_q   <= lo_sum[HALF];
        lo_q   <= lo_sum[HALF-1:0];
        hi_q   <= val_i[DATA_W-1:HALF];
      end else if (busy_q) begin
        busy_q  <= 1'b0;
        done_o  <= 1'b1;
        res_o   <= res_d;
        flags_o <= flags_d;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_q));
  p_busy_one_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen import ptr_agen_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 6,
  parameter int IMM_W      = 6,
  parameter int REG_W      = 5,
  parameter int PTR_BASE   = 26,
  parameter int REG_CNT    = 32,
  parameter int IO_CNT     = 64,
  parameter int SRAM_BYTES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [1:0]        mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              ea_valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [1:0]        region_o,
  output logic [ADDR_W-1:0] ptr_new_o,
  output logic              ptr_wb_o,
  output logic [REG_W-1:0]  ptr_reg_o,
  input  logic              word_start_i,
  input  logic              word_sub_i,
  input  logic [ADDR_W-1:0] word_val_i,
  input  logic [IMM_W-1:0]  word_imm_i,
  output logic              word_done_o,
  output logic [ADDR_W-1:0] word_res_o,
  output logic [4:0]        word_flags_o
);
  logic              ok_d, wb_d;
  logic [ADDR_W-1:0] ea_d, new_d;
  logic [REG_W-1:0]  reg_d;
  region_e           rgn_d;
  word_flags_t       wflags;

  ptr_addr_calc #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .REG_W(REG_W),
    .PTR_BASE(PTR_BASE), .PTR_CNT(3)
  ) i_calc (
    .sel_i    (ptr_sel_e'(ptr_sel_i)),
    .mode_i   (agen_mode_e'(mode_i)),
    .disp_i   (disp_i),
    .ptr_i    (ptr_i),
    .ok_o     (ok_d),
    .ea_o     (ea_d),
    .new_ptr_o(new_d),
    .wb_o     (wb_d),
    .reg_o    (reg_d)
  );

  data_region_decode #(
    .ADDR_W(ADDR_W), .REG_CNT(REG_CNT), .IO_CNT(IO_CNT), .SRAM_BYTES(SRAM_BYTES)
  ) i_rgn (
    .addr_i  (ea_d),
    .region_o(rgn_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_valid_o <= 1'b0;
      ptr_wb_o   <= 1'b0;
      ea_o       <= '0;
      ptr_new_o  <= '0;
      region_o   <= '0;
      ptr_reg_o  <= '0;
    end else begin
      ea_valid_o <= req_i && ok_d;
      ptr_wb_o   <= req_i && ok_d && wb_d;
      if (req_i && ok_d) begin
        ea_o      <= ea_d;
        ptr_new_o <= new_d;
        region_o  <= rgn_d;
        ptr_reg_o <= reg_d;
      end
    end
  end

  word_imm_unit #(.DATA_W(ADDR_W), .IMM_W(IMM_W)) i_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(word_start_i),
    .sub_i  (word_sub_i),
    .val_i  (word_val_i),
    .imm_i  (word_imm_i),
    .done_o (word_done_o),
    .res_o  (word_res_o),
    .flags_o(wflags)
  );
  assign word_flags_o = wflags;

  p_valid_after_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_valid_o |-> $past(req_i));
  p_wb_needs_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wb_o |-> ea_valid_o);
  p_wb_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wb_o |-> (ptr_new_o == ea_o || ptr_new_o == ea_o + ADDR_W'(1)));
  p_regs_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ea_valid_o && region_o == RGN_REGS) |-> ({1'b0, ea_o} < (ADDR_W+1)'(REG_CNT)));
endmodule

// File: tb/test_ptr_agen.sv
module test_ptr_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  sel = '0, mode = '0;
  logic [5:0]  disp = '0;
  logic [15:0] ptr = '0;
  logic        ea_valid, ptr_wb;
  logic [15:0] ea, ptr_new;
  logic [1:0]  region;
  logic [4:0]  ptr_reg;
  logic        w_start = 1'b0, w_sub = 1'b0;
  logic [15:0] w_val = '0;
  logic [5:0]  w_imm = '0;
  logic        w_done;
  logic [15:0] w_res;
  logic [4:0]  w_flags;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ptr_agen i_ptr_agen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ptr_sel_i(sel), .mode_i(mode),
    .disp_i(disp), .ptr_i(ptr), .ea_valid_o(ea_valid), .ea_o(ea),
    .region_o(region), .ptr_new_o(ptr_new), .ptr_wb_o(ptr_wb),
    .ptr_reg_o(ptr_reg), .word_start_i(w_start), .word_sub_i(w_sub),
    .word_val_i(w_val), .word_imm_i(w_imm), .word_done_o(w_done),
    .word_res_o(w_res), .word_flags_o(w_flags)
  );

  task automatic chk(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_region(logic [15:0] a);
    if (a < 16'h20) return 2'd0;
    if (a < 16'h60) return 2'd1;
    if (a < 16'hE0) return 2'd2;
    return 2'd3;
  endfunction

  task automatic issue(logic [1:0] s, logic [1:0] m, logic [5:0] q, logic [15:0] p);
    @(negedge clk);
    req = 1'b1; sel = s; mode = m; disp = q; ptr = p;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic addr_case(string tag, logic [1:0] s, logic [1:0] m, logic [5:0] q,
                           logic [15:0] p, logic [15:0] exp_ea, logic [15:0] exp_new,
                           logic exp_wb);
    issue(s, m, q, p);
    chk(tag, "valid", ea_valid, 1);
    chk(tag, "ea", ea, exp_ea);
    chk(tag, "new_ptr", ptr_new, exp_new);
    chk(tag, "wb", ptr_wb, exp_wb);
    chk("R2", "pair_reg", ptr_reg, 26 + 2 * s);
    chk("R8", "region", region, exp_region(exp_ea));
  endtask

  task automatic t_reset();
    chk("R1", "valid", ea_valid, 0); chk("R1", "ea", ea, 0);
    chk("R1", "new", ptr_new, 0);   chk("R1", "wb", ptr_wb, 0);
    chk("R1", "region", region, 0); chk("R1", "reg", ptr_reg, 0);
    chk("R1", "done", w_done, 0);   chk("R1", "res", w_res, 0);
    chk("R1", "flags", w_flags, 0);
  endtask

  task automatic t_plain();
    addr_case("R3", 2'd1, 2'd0, 6'd9, 16'h0045, 16'h0045, 16'h0045, 0);
    addr_case("R3", 2'd2, 2'd0, 6'd0, 16'h1234, 16'h1234, 16'h1234, 0);
    @(negedge clk);
    chk("R3", "valid_drops", ea_valid, 0);
  endtask

  task automatic t_post();
    addr_case("R4", 2'd0, 2'd1, 6'd0, 16'hFFFF, 16'hFFFF, 16'h0000, 1);
    addr_case("R4", 2'd2, 2'd1, 6'd0, 16'h0010, 16'h0010, 16'h0011, 1);
  endtask

  task automatic t_pre();
    addr_case("R5", 2'd1, 2'd2, 6'd0, 16'h0000, 16'hFFFF, 16'hFFFF, 1);
    addr_case("R5", 2'd2, 2'd2, 6'd0, 16'h0061, 16'h0060, 16'h0060, 1);
  endtask

  task automatic t_disp();
    addr_case("R6", 2'd2, 2'd3, 6'd63, 16'h0020, 16'h005F, 16'h0020, 0);
    addr_case("R6", 2'd1, 2'd3, 6'd32, 16'hFFF0, 16'h0010, 16'hFFF0, 0);
    addr_case("R6", 2'd1, 2'd3, 6'd0, 16'h0070, 16'h0070, 16'h0070, 0);
  endtask

  task automatic t_reject();
    issue(2'd0, 2'd3, 6'd5, 16'h0040);
    chk("R7", "x_disp_valid", ea_valid, 0);
    chk("R7", "x_disp_wb", ptr_wb, 0);
    issue(2'd3, 2'd1, 6'd0, 16'h0040);
    chk("R7", "rsv_valid", ea_valid, 0);
    chk("R7", "rsv_wb", ptr_wb, 0);
  endtask

  task automatic t_region();
    logic [15:0] pts [6] = '{16'h001F, 16'h0020, 16'h005F, 16'h0060, 16'h00DF, 16'h00E0};
    for (int i = 0; i < 6; i++) begin
      issue(2'd0, 2'd0, 6'd0, pts[i]);
      chk("R8", "boundary", region, exp_region(pts[i]));
    end
  endtask

  task automatic word_case(string tag, logic sub, logic [15:0] v, logic [5:0] k);
    logic [16:0] wide;
    logic [15:0] r;
    logic c, n, z, vf;
    wide = sub ? ({1'b0, v} - {11'b0, k}) : ({1'b0, v} + {11'b0, k});
    r  = wide[15:0];
    c  = wide[16];
    n  = r[15];
    z  = (r == 16'h0);
    vf = sub ? (v[15] && !r[15]) : (!v[15] && r[15]);
    @(negedge clk);
    w_start = 1'b1; w_sub = sub; w_val = v; w_imm = k;
    @(posedge clk);
    @(negedge clk);
    w_start = 1'b0;
    chk(tag, "not_done_yet", w_done, 0);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "done", w_done, 1);
    chk(tag, "result", w_res, r);
    chk("R11", "flags", w_flags, {n ^ vf, vf, n, z, c});
  endtask

  task automatic t_word();
    word_case("R9", 1'b0, 16'h00FF, 6'd1);
    word_case("R9", 1'b0, 16'h7FFF, 6'd1);
    word_case("R9", 1'b0, 16'hFFC1, 6'd63);
    word_case("R10", 1'b1, 16'h0000, 6'd1);
    word_case("R10", 1'b1, 16'h8000, 6'd1);
    word_case("R10", 1'b1, 16'h003F, 6'd63);
    word_case("R10", 1'b1, 16'h1234, 6'd20);
  endtask

  task automatic t_busy();
    @(negedge clk);
    w_start = 1'b1; w_sub = 1'b0; w_val = 16'h0100; w_imm = 6'd5;
    @(posedge clk);
    @(negedge clk);
    w_sub = 1'b1; w_val = 16'h0000; w_imm = 6'd7;
    @(posedge clk);
    @(negedge clk);
    w_start = 1'b0;
    chk("R12", "first_done", w_done, 1);
    chk("R12", "first_res", w_res, 16'h0105);
    @(posedge clk);
    @(negedge clk);
    chk("R12", "no_second_done", w_done, 0);
    chk("R12", "res_held", w_res, 16'h0105);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_post();
    t_pre();
    t_disp();
    t_reject();
    t_region();
    t_word();
    t_busy();
    finish_run();
  end
endmodule